// File: doc/BRIEF.md
# Frame-Synchronised Serial Port with Split Host Data Registers

This block is a full-duplex serial port that moves words of 8 to 32 bits between a 16-bit host bus and a pair of serial lines. Each direction is reached through a high and a low 16-bit data register. On the transmit side the host loads a holding pair. The pair is copied into a shift register, then sent most significant bit first, one bit per clock. A one-cycle frame-sync pulse leads each frame. On the receive side a frame-sync pulse starts sampling. Each finished word passes from the shift register to a buffer register, and then to a host-readable data pair.

The host access to the low register is the event that moves the port forward. A write to the low transmit register marks the holding pair as full. A read of the low receive register frees the receive pair for the next copy. Words wider than 16 bits must therefore be written high first and low second, and read high first and low second. A frame is one phase of one or more words of equal length. The serial bit clock is the block clock.

Top module: `frame_serial_port`

## Requirements
- R1: The word-length code selects the serial word size: 000 = 8, 001 = 12, 010 = 16, 011 = 20, 100 = 24 and 101 = 32 bits (110 and 111 also give 32). A received word is right-aligned in {rxDataHi, rxDataLo}, and bits above the word size read zero. The transmitted word is the low bits of {high register, low register}.
- R2: A write to the low transmit register (hostWrLo) marks the holding pair full and clears txReady in the next cycle. A write to the high register alone starts no frame and leaves txReady set. txReady sets again in the cycle after the pair is copied into the shift register.
- R3: When an idle transmitter holds a full pair, it copies the pair and drives txSync high for exactly one cycle. The first data bit follows in the next cycle. Bits go out most significant first, one per clock, and txData is 0 whenever no data bit is being sent.
- R4: The frame-length field holds the number of words per frame minus one. All words of a frame go out back to back after the single sync pulse. Four 8-bit words in a four-word frame put the same 32 bits on the line as one 32-bit word in a one-word frame.
- R5: If no word is waiting when a word inside a frame must start, that word is sent as all zeros.
- R6: If a word is waiting when the last bit of a frame has been sent, the next sync pulse comes in the very next cycle, so one-word frames of 8 bits repeat every 9 cycles.
- R7: A high rxSync starts a frame. rxData is sampled on each of the following clocks for frame-length-plus-one words of the configured size. Each finished word goes from the shift register into the buffer register, and on a later clock into the readable pair.
- R8: rxReady sets in the cycle after a buffer-to-data copy. It clears on the clock where rxReadLo is high. While it is set, the readable pair does not change.
- R9: If a word finishes while both the buffer register and the readable pair are full, rxOverrun sets and the word is discarded. A read of the low register clears rxOverrun, unless a new overrun occurs on the same clock.
- R10: After reset txReady is 1, rxReady, rxOverrun, txSync and txData are 0, and the readable pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWordLen | input | 3 | Word-length code, held stable while the port is busy |
| cfgFrameLen | input | 7 | Words per frame minus one |
| hostWrHi | input | 1 | Write strobe for the high transmit register |
| hostWrLo | input | 1 | Write strobe for the low transmit register; starts the transfer |
| hostWrData | input | 16 | Host write data |
| txReady | output | 1 | Transmit holding pair may be written |
| rxReadLo | input | 1 | Host read strobe for the low receive register |
| rxDataHi | output | 16 | Upper half of the readable receive pair |
| rxDataLo | output | 16 | Lower half of the readable receive pair |
| rxReady | output | 1 | Readable receive pair holds an unread word |
| rxOverrun | output | 1 | A received word was discarded |
| txSync | output | 1 | Transmit frame-sync pulse |
| txData | output | 1 | Transmit serial data |
| rxSync | input | 1 | Receive frame-sync pulse |
| rxData | input | 1 | Receive serial data |

## Verification
The bench loops the transmit pins back to the receive pins. It goes after the following corner cases:
- A high-register write with no low write. A port that started on it would emit a stray sync pulse.
- A 4×8-bit frame compared bit for bit with a 32-bit frame. A word counter that paused between words, or re-synced between them, would shift or split the stream.
- Partial widths with all-ones upper bits. Bad masking or bad alignment would leak those bits into the received value.
- A frame with a missing word, and back-to-back frames. A port that did not fill the gap with zeros, or that waited an idle cycle, would break the frame timing.
- Three words with no reads. This checks that the third word is dropped and flagged, rather than written over the unread pair.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic txLoad;     // copy holding pair into transmit shifter
    logic txZero;     // fill transmit shifter with a zero word
    logic txShift;    // advance transmit shifter by one bit
    logic txDrive;    // a data bit is on the line this cycle
    logic rxShift;    // sample one receive bit
    logic rxCapture;  // finished word into buffer register
    logic rxCopy;     // buffer register into readable pair
  } spStrobe_t;

  function automatic int unsigned wordBits(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 12;
      3'd2:    return 16;
      3'd3:    return 20;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int FrameLenWidth = 7,
  parameter int CntWidth      = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               cfgWordLen,
  input  logic [FrameLenWidth-1:0] cfgFrameLen,
  input  logic                     hostWrLo,
  input  logic                     rxReadLo,
  input  logic                     rxSync,
  output spStrobe_t                strobe,
  output logic                     txReady,
  output logic                     txSync,
  output logic                     rxReady,
  output logic                     rxOverrun
);

  typedef enum logic [1:0] {TX_IDLE, TX_SYNC, TX_DATA} txState_t;

  txState_t                 txState;
  logic [CntWidth-1:0]      txBit, rxBit, lastBit;
  logic [FrameLenWidth-1:0] txWord, rxWord;
  logic                     txPending, rxActive, rbrFull;
  logic                     txWordEnd, txFrameEnd, rxWordEnd, overrunSet;

  assign lastBit = CntWidth'(wordBits(cfgWordLen) - 1);

  always_comb begin
    txWordEnd  = (txState == TX_DATA) && (txBit == lastBit);
    txFrameEnd = txWordEnd && (txWord == cfgFrameLen);
    rxWordEnd  = rxActive && (rxBit == lastBit);

    strobe           = '0;
    strobe.txDrive   = (txState == TX_DATA);
    strobe.txShift   = (txState == TX_DATA) && !txWordEnd;
    strobe.txLoad    = txPending && ((txState == TX_IDLE) || txWordEnd);
    strobe.txZero    = txWordEnd && !txFrameEnd && !txPending;
    strobe.rxShift   = rxActive;
    strobe.rxCopy    = rbrFull && !rxReady;
    strobe.rxCapture = rxWordEnd && (!rbrFull || strobe.rxCopy);
    overrunSet       = rxWordEnd && rbrFull && !strobe.rxCopy;
  end

  assign txReady = !txPending;
  assign txSync  = (txState == TX_SYNC);

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      txBit     <= '0;
      txWord    <= '0;
      txPending <= 1'b0;
    end else begin
      if (hostWrLo)           txPending <= 1'b1;
      else if (strobe.txLoad) txPending <= 1'b0;
      case (txState)
        TX_IDLE: if (strobe.txLoad) begin
          txState <= TX_SYNC;
          txWord  <= '0;
        end
        TX_SYNC: begin
          txState <= TX_DATA;
          txBit   <= '0;
        end
        default: begin
          if (txWordEnd) begin
            txBit <= '0;
            if (txFrameEnd) begin
              txWord  <= '0;
              txState <= txPending ? TX_SYNC : TX_IDLE;
            end else begin
              txWord <= txWord + 1'b1;
            end
          end else begin
            txBit <= txBit + 1'b1;
          end
        end
      endcase
    end
  end

  // receive sequencing and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive  <= 1'b0;
      rxBit     <= '0;
      rxWord    <= '0;
      rbrFull   <= 1'b0;
      rxReady   <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      if (!rxActive) begin
        if (rxSync) begin
          rxActive <= 1'b1;
          rxBit    <= '0;
          rxWord   <= '0;
        end
      end else if (rxWordEnd) begin
        rxBit <= '0;
        if (rxWord == cfgFrameLen) rxActive <= 1'b0;
        else                       rxWord   <= rxWord + 1'b1;
      end else begin
        rxBit <= rxBit + 1'b1;
      end

      if (strobe.rxCapture)   rbrFull <= 1'b1;
      else if (strobe.rxCopy) rbrFull <= 1'b0;

      if (strobe.rxCopy) rxReady <= 1'b1;
      else if (rxReadLo) rxReady <= 1'b0;

      if (overrunSet)    rxOverrun <= 1'b1;
      else if (rxReadLo) rxOverrun <= 1'b0;
    end
  end

endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int HostWidth = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cfgWordLen,
  input  logic                 hostWrHi,
  input  logic                 hostWrLo,
  input  logic [HostWidth-1:0] hostWrData,
  input  spStrobe_t            strobe,
  input  logic                 rxData,
  output logic                 txData,
  output logic [HostWidth-1:0] rxDataHi,
  output logic [HostWidth-1:0] rxDataLo
);

  localparam int WordW = 2 * HostWidth;

  logic [HostWidth-1:0] holdHi, holdLo;
  logic [WordW-1:0]     txShReg, rxShReg, rxBuf, rxHold, wordMask, rxNext;
  int unsigned          bits;

  always_comb begin
    bits     = wordBits(cfgWordLen);
    wordMask = (bits >= WordW) ? '1 : ((WordW'(1) << bits) - WordW'(1));
    rxNext   = {rxShReg[WordW-2:0], rxData} & wordMask;
  end

  assign txData   = strobe.txDrive & txShReg[WordW-1];
  assign rxDataHi = rxHold[WordW-1:HostWidth];
  assign rxDataLo = rxHold[HostWidth-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdHi  <= '0;
      holdLo  <= '0;
      txShReg <= '0;
      rxShReg <= '0;
      rxBuf   <= '0;
      rxHold  <= '0;
    end else begin
      if (hostWrHi) holdHi <= hostWrData;
      if (hostWrLo) holdLo <= hostWrData;

      // word is left-aligned so the shifter's top bit is always the next bit out
      if (strobe.txLoad)       txShReg <= {holdHi, holdLo} << (WordW - bits);
      else if (strobe.txZero)  txShReg <= '0;
      else if (strobe.txShift) txShReg <= {txShReg[WordW-2:0], 1'b0};

      if (strobe.rxShift)   rxShReg <= {rxShReg[WordW-2:0], rxData};
      if (strobe.rxCapture) rxBuf   <= rxNext;
      if (strobe.rxCopy)    rxHold  <= rxBuf;
    end
  end

endmodule

// File: rtl/frame_serial_port.sv
module frame_serial_port
  import sp_pkg::*;
#(
  parameter int HostWidth     = 16,
  parameter int FrameLenWidth = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [2:0]               cfgWordLen,
  input  logic [FrameLenWidth-1:0] cfgFrameLen,
  input  logic                     hostWrHi,
  input  logic                     hostWrLo,
  input  logic [HostWidth-1:0]     hostWrData,
  output logic                     txReady,
  input  logic                     rxReadLo,
  output logic [HostWidth-1:0]     rxDataHi,
  output logic [HostWidth-1:0]     rxDataLo,
  output logic                     rxReady,
  output logic                     rxOverrun,
  output logic                     txSync,
  output logic                     txData,
  input  logic                     rxSync,
  input  logic                     rxData
);

  localparam int CntWidth = $clog2(2 * HostWidth);

  spStrobe_t strobe;

  sp_ctrl #(
    .FrameLenWidth(FrameLenWidth),
    .CntWidth     (CntWidth)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWordLen (cfgWordLen),
    .cfgFrameLen(cfgFrameLen),
    .hostWrLo   (hostWrLo),
    .rxReadLo   (rxReadLo),
    .rxSync     (rxSync),
    .strobe     (strobe),
    .txReady    (txReady),
    .txSync     (txSync),
    .rxReady    (rxReady),
    .rxOverrun  (rxOverrun)
  );

  sp_datapath #(
    .HostWidth(HostWidth)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWordLen(cfgWordLen),
    .hostWrHi  (hostWrHi),
    .hostWrLo  (hostWrLo),
    .hostWrData(hostWrData),
    .strobe    (strobe),
    .rxData    (rxData),
    .txData    (txData),
    .rxDataHi  (rxDataHi),
    .rxDataLo  (rxDataLo)
  );

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int HostWidth = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 hostWrLo,
  input logic                 txReady,
  input logic                 txSync,
  input logic                 txData,
  input logic                 rxReadLo,
  input logic                 rxReady,
  input logic                 rxOverrun,
  input logic [HostWidth-1:0] rxDataHi,
  input logic [HostWidth-1:0] rxDataLo
);

  AST_LOW_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    hostWrLo |=> !txReady);  // R2

  AST_READY_HELD_WITHOUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !hostWrLo) |=> txReady);  // R2

  AST_SYNC_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    txSync |=> !txSync);  // R3

  AST_NO_DATA_DURING_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    txSync |-> !txData);  // R3

  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (rxReadLo && rxReady) |=> !rxReady);  // R8

  AST_PAIR_HELD_WHILE_READY: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !rxReadLo) |=> (rxReady && $stable(rxDataLo) && $stable(rxDataHi)));  // R8

  AST_OVERRUN_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxReady));  // R9

endmodule

bind frame_serial_port sp_checker #(.HostWidth(HostWidth)) u_chk (.*);

// File: tb/tb_frame_serial_port.sv
module tb_frame_serial_port;

  localparam int HW = 16;
  localparam int FW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]    wl = 3'd5;
  logic [FW-1:0] fl = '0;
  logic          wrHi = 1'b0, wrLo = 1'b0, rdLo = 1'b0;
  logic [HW-1:0] wrData = '0;
  logic          txReady, rxReady, rxOverrun, txSync, txData;
  logic [HW-1:0] rxHi, rxLo;

  frame_serial_port #(.HostWidth(HW), .FrameLenWidth(FW)) dut (
    .clk(clk), .rstN(rstN), .cfgWordLen(wl), .cfgFrameLen(fl),
    .hostWrHi(wrHi), .hostWrLo(wrLo), .hostWrData(wrData), .txReady(txReady),
    .rxReadLo(rdLo), .rxDataHi(rxHi), .rxDataLo(rxLo), .rxReady(rxReady),
    .rxOverrun(rxOverrun), .txSync(txSync), .txData(txData),
    .rxSync(txSync), .rxData(txData)
  );

  int compared = 0, mismatched = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic int sizeOf(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  bit            mPending, mRbrFull, mReady, mOvr, mRxActive, eSync, eData;
  logic [HW-1:0] mHoldHi, mHoldLo;
  int            mTxState, mTxWord, mRxCnt, mRxWord, n;
  bit            mTxBits[$];
  logic [31:0]   mRxAcc, mRbr, mDrr, newW;
  bit            copyNow, complete, dBit, sBit;

  function automatic void loadBits(input logic [31:0] w, input int cnt);
    mTxBits.delete();
    for (int i = cnt - 1; i >= 0; i--) mTxBits.push_back(w[i]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPending = 0; mRbrFull = 0; mReady = 0; mOvr = 0; mRxActive = 0;
      eSync = 0; eData = 0; mHoldHi = '0; mHoldLo = '0;
      mTxState = 0; mTxWord = 0; mRxCnt = 0; mRxWord = 0;
      mRxAcc = '0; mRbr = '0; mDrr = '0; mTxBits.delete();
    end else begin
      n = sizeOf(wl);
      dBit = eData; sBit = eSync; complete = 0; newW = '0;
      copyNow = mRbrFull && !mReady;
      if (mRxActive) begin
        mRxAcc = {mRxAcc[30:0], dBit};
        mRxCnt++;
        if (mRxCnt == n) begin
          complete = 1;
          newW = (n == 32) ? mRxAcc : (mRxAcc & ((32'd1 << n) - 32'd1));
          mRxCnt = 0;
          if (mRxWord == int'(fl)) mRxActive = 0; else mRxWord++;
        end
      end else if (sBit) begin
        mRxActive = 1; mRxCnt = 0; mRxWord = 0; mRxAcc = '0;
      end
      if (rdLo) begin mReady = 0; mOvr = 0; end
      if (copyNow) begin mDrr = mRbr; mReady = 1; mRbrFull = 0; end
      if (complete) begin
        if (mRbrFull) mOvr = 1;
        else begin mRbr = newW; mRbrFull = 1; end
      end

      case (mTxState)
        0: if (mPending) begin
          loadBits({mHoldHi, mHoldLo}, n); mPending = 0; mTxState = 1; mTxWord = 0;
        end
        1: mTxState = 2;
        default: begin
          void'(mTxBits.pop_front());
          if (mTxBits.size() == 0) begin
            if (mTxWord == int'(fl)) begin
              if (mPending) begin
                loadBits({mHoldHi, mHoldLo}, n); mPending = 0; mTxState = 1; mTxWord = 0;
              end else mTxState = 0;
            end else begin
              mTxWord++;
              if (mPending) begin loadBits({mHoldHi, mHoldLo}, n); mPending = 0; end
              else loadBits('0, n);
            end
          end
        end
      endcase
      if (wrHi) mHoldHi = wrData;
      if (wrLo) begin mHoldLo = wrData; mPending = 1; end
      eSync = (mTxState == 1);
      eData = (mTxState == 2) ? mTxBits[0] : 1'b0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check("R3 txSync", {31'd0, txSync}, {31'd0, eSync});
      check("R3 txData", {31'd0, txData}, {31'd0, eData});
      check("R2 txReady", {31'd0, txReady}, {31'd0, !mPending});
      check("R8 rxReady", {31'd0, rxReady}, {31'd0, mReady});
      check("R9 rxOverrun", {31'd0, rxOverrun}, {31'd0, mOvr});
      check("R7 rx pair", {rxHi, rxLo}, mDrr);
    end
  end

  // ---------------- host-side helpers ----------------
  int          cyc = 0;
  int          syncTimes[$];
  logic [31:0] rxGot[$];
  bit          autoRead = 0;

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rstN && txSync) syncTimes.push_back(cyc);

  always @(negedge clk) begin
    if (autoRead) begin
      if (rxReady && !rdLo) begin
        rdLo = 1'b1;
        rxGot.push_back({rxHi, rxLo});
      end else rdLo = 1'b0;
    end
  end

  task automatic sendWord(input logic [31:0] w);
    do @(negedge clk); while (!txReady);
    wrHi = 1'b1; wrData = w[31:16];
    @(negedge clk);
    wrHi = 1'b0; wrLo = 1'b1; wrData = w[15:0];
    @(negedge clk);
    wrLo = 1'b0;
  endtask

  task automatic captureLine(output logic [31:0] v);
    v = '0;
    do @(negedge clk); while (!txSync);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      v = {v[30:0], txData};
    end
  endtask

  task automatic waitRx(input int cnt);
    for (int i = 0; i < 600 && rxGot.size() < cnt; i++) @(negedge clk);
  endtask

  task automatic expectRx(input string tag, input logic [31:0] exp);
    logic [31:0] got;
    got = (rxGot.size() > 0) ? rxGot.pop_front() : 32'hDEAD_DEAD;
    check(tag, got, exp);
  endtask

  task automatic oneWord(input logic [2:0] code, input logic [31:0] w, input logic [31:0] exp,
                         input string tag);
    @(negedge clk); wl = code; fl = '0;
    sendWord(w);
    waitRx(1);
    expectRx(tag, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  logic [31:0] line32, line8;

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 txReady", {31'd0, txReady}, 32'd1);
    check("R10 rxReady", {31'd0, rxReady}, 32'd0);
    check("R10 rxOverrun", {31'd0, rxOverrun}, 32'd0);
    check("R10 txSync", {31'd0, txSync}, 32'd0);
    check("R10 txData", {31'd0, txData}, 32'd0);
    check("R10 pair", {rxHi, rxLo}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: high write alone starts nothing
    wrHi = 1'b1; wrData = 16'hBEEF;
    @(negedge clk); wrHi = 1'b0;
    repeat (8) @(negedge clk);
    check("R2 no sync after high write", syncTimes.size(), 0);
    check("R2 txReady after high write", {31'd0, txReady}, 32'd1);

    autoRead = 1;
    // R3/R1: one 32-bit word, MSB first
    wl = 3'd5; fl = '0;
    fork
      sendWord(32'hA5C3_1234);
      captureLine(line32);
    join
    check("R3 32-bit line MSB first", line32, 32'hA5C3_1234);
    waitRx(1);
    expectRx("R7 32-bit receive", 32'hA5C3_1234);

    // R4: four 8-bit words in one frame give the same line
    @(negedge clk); wl = 3'd0; fl = 7'd3;
    fork
      begin
        sendWord(32'h0000_00A5); sendWord(32'h0000_00C3);
        sendWord(32'h0000_0012); sendWord(32'h0000_0034);
      end
      captureLine(line8);
    join
    check("R4 4x8 line equals 1x32 line", line8, line32);
    waitRx(4);
    expectRx("R4 byte 0", 32'hA5); expectRx("R4 byte 1", 32'hC3);
    expectRx("R4 byte 2", 32'h12); expectRx("R4 byte 3", 32'h34);

    // R1: partial widths, upper bits dropped
    oneWord(3'd1, 32'hFFFF_FABC, 32'h0000_0ABC, "R1 12-bit");
    oneWord(3'd3, 32'hFFF1_2345, 32'h0001_2345, "R1 20-bit");
    oneWord(3'd4, 32'hFFAB_CDEF, 32'h00AB_CDEF, "R1 24-bit");
    oneWord(3'd2, 32'h9999_5A5A, 32'h0000_5A5A, "R1 16-bit");

    // R5: second word of a two-word frame never written
    @(negedge clk); wl = 3'd2; fl = 7'd1;
    sendWord(32'h0000_8001);
    waitRx(2);
    expectRx("R5 first word", 32'h8001);
    expectRx("R5 missing word sent as zero", 32'h0);

    // R6: back-to-back one-word frames of 8 bits
    @(negedge clk); wl = 3'd0; fl = '0;
    syncTimes.delete();
    sendWord(32'h11); sendWord(32'h22); sendWord(32'h33);
    waitRx(3);
    check("R6 sync spacing 1", syncTimes[1] - syncTimes[0], 9);
    check("R6 sync spacing 2", syncTimes[2] - syncTimes[1], 9);
    expectRx("R6 word a", 32'h11); expectRx("R6 word b", 32'h22); expectRx("R6 word c", 32'h33);

    // R9: three words with no reads
    @(negedge clk); autoRead = 0; rdLo = 1'b0; wl = 3'd0; fl = 7'd2;
    sendWord(32'h0A); sendWord(32'h0B); sendWord(32'h0C);
    repeat (40) @(negedge clk);
    check("R9 overrun set", {31'd0, rxOverrun}, 32'd1);
    check("R9 first word kept", {rxHi, rxLo}, 32'h0A);
    rdLo = 1'b1; @(negedge clk); rdLo = 1'b0; @(negedge clk);
    check("R9 overrun cleared by read", {31'd0, rxOverrun}, 32'd0);
    check("R9 buffered word follows", {rxHi, rxLo}, 32'h0B);
    check("R8 ready after copy", {31'd0, rxReady}, 32'd1);
    rdLo = 1'b1; @(negedge clk); rdLo = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 third word discarded", {31'd0, rxReady}, 32'd0);

    finishRun();
  end

endmodule